// File: doc/BRIEF.md
# Inbound DMA Window Decoder

This unit sits on the inbound path of a PCI host bridge. It keeps the programming of four DMA address windows and decides, in one combinational pass, whether a 32-bit single-address bus address falls into one of them. Each window has a base register, a mask register and a translated-base register. The base register carries an enable bit and a mode bit. In direct mode the unit produces the system address at once. In scatter-gather mode it produces the address of the page-table entry to fetch. The fetch itself happens outside the unit.

A control register holds bridge-wide settings. One of its bits reserves a legacy hole from 0x80000 to 0xFFFFF, which then never matches a window. The last window is always in scatter-gather mode. It takes part in single-address lookups only while its dual-address enable bit is clear. Software programs the unit through a plain CSR port. Writes take effect on the next clock edge, and reads return combinationally.

Top module: `dmaw_unit`

## Requirements
- R1: After reset, every register reads 0, except the last window's base register, which reads 0x2 (scatter-gather bit 1 set).
- R2: Window base writes keep bits 31:20, bit 1 (scatter-gather) and bit 0 (enable). For the last window, bit 40 (dual-address enable) is also kept and bit 1 always reads 1. Base registers sit at 0x000 + 0x040*n.
- R3: Mask writes at 0x100 + 0x040*n keep only bits 31:20. Translated-base writes at 0x200 + 0x040*n keep only bits 34:10.
- R4: The control register at 0x300 changes only in bit positions 0x00001CFF0FC7FF. All other bits hold their value.
- R5: Offsets that are not defined read 0, and writes to them change no register.
- R6: A window hits when its enable bit is set and (address AND NOT (mask OR 0xFFFFF)) equals base bits 31:20 placed at 31:20.
- R7: On a direct-mode hit (bit 1 clear), sys_addr_o = (translated base AND NOT extended mask) OR (address AND extended mask), and sg_o = 0.
- R8: On a scatter-gather hit, sg_o = 1 and pte_addr_o = (translated base AND NOT (mask >> 10)) OR ((address AND (mask OR 0xFE000)) >> 10).
- R9: When more than one window hits, the lowest window index wins. win_idx_o reports that index.
- R10: The last window takes part in lookups only while its base bit 40 is 0.
- R11: While control bit 5 is 1, no address from 0x80000 to 0xFFFFF hits any window.
- R12: When no window hits, hit_o, sg_o, sys_addr_o and pte_addr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 10 | CSR byte offset |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data (combinational) |
| lk_addr_i | input | 32 | Bus address to look up |
| hit_o | output | 1 | Address falls in an enabled window |
| win_idx_o | output | 2 | Index of the winning window |
| sg_o | output | 1 | Winning window is in scatter-gather mode |
| sys_addr_o | output | 35 | Translated system address (direct hit) |
| pte_addr_o | output | 35 | Page-table-entry address (scatter-gather hit) |

## Verification
The bench writes all ones to every register and reads back the kept bits. A write mask that is wrong leaves stray bits that later enter the hit compare. Two windows are programmed over the same range so that both hit at once, and the test checks that the lower index wins; a reversed priority loop reports window 2. The hole is probed inside it, just below it and with control bit 5 off, so an off-by-one bound or a test of the wrong bit misses. The dual-address bit on the last window is set and then cleared around one fixed address. Scatter-gather addresses are compared against values worked out by hand, which catches a wrong shift distance or a missing 0xFE000 term.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int unsigned BUS_AW  = 32;
  localparam int unsigned SYS_AW  = 35;
  localparam int unsigned CSR_DW  = 64;
  localparam int unsigned CSR_AW  = 10;
  localparam int unsigned HI_W    = 12;   // base/mask bits 31:20
  localparam int unsigned TBA_W   = 25;   // translated base bits 34:10
  localparam int unsigned HOLE_BIT = 5;
  localparam logic [CSR_DW-1:0] CTL_WMASK = 64'h00001CFF0FC7FF;
  localparam logic [BUS_AW-1:0] PAGE_MASK = 32'h000FFFFF;
  localparam logic [BUS_AW-1:0] SG_IDX_MASK = 32'h000FE000;
  localparam logic [BUS_AW-1:0] HOLE_LO = 32'h00080000;
  localparam logic [BUS_AW-1:0] HOLE_HI = 32'h000FFFFF;

  typedef enum logic [1:0] {
    GRP_BASE = 2'd0,
    GRP_MASK = 2'd1,
    GRP_TBA  = 2'd2,
    GRP_CTL  = 2'd3
  } csr_grp_e;

  typedef struct packed {
    logic             en;
    logic             sg;
    logic             dac;
    logic [HI_W-1:0]  base_hi;
    logic [HI_W-1:0]  mask_hi;
    logic [TBA_W-1:0] tba_hi;
  } win_cfg_t;
endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs
  import dmaw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                csr_we_i,
  input  logic [CSR_AW-1:0]   csr_addr_i,
  input  logic [CSR_DW-1:0]   csr_wdata_i,
  output logic [CSR_DW-1:0]   csr_rdata_o,
  output win_cfg_t            cfg_o [NUM_WIN],
  output logic                hole_en_o
);
  csr_grp_e             grp;
  logic [1:0]           widx;
  logic                 aligned, ctl_sel, win_sel;
  logic [CSR_DW-1:0]    ctl_q;

  assign grp     = csr_grp_e'(csr_addr_i[9:8]);
  assign widx    = csr_addr_i[7:6];
  assign aligned = (csr_addr_i[5:0] == 6'd0);
  assign ctl_sel = aligned && (grp == GRP_CTL) && (widx == 2'd0);
  assign win_sel = aligned && (grp != GRP_CTL) && (32'(widx) < NUM_WIN);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam bit LAST = (w == NUM_WIN - 1);
    win_cfg_t q;
    logic     hit_sel, wr_base, wr_mask, wr_tba;

    assign hit_sel = csr_we_i && win_sel && (widx == 2'(w));
    assign wr_base = hit_sel && (grp == GRP_BASE);
    assign wr_mask = hit_sel && (grp == GRP_MASK);
    assign wr_tba  = hit_sel && (grp == GRP_TBA);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q    <= '0;
        q.sg <= LAST;
      end else begin
        if (wr_base) begin
          q.en      <= csr_wdata_i[0];
          q.sg      <= LAST ? 1'b1 : csr_wdata_i[1];
          q.dac     <= LAST ? csr_wdata_i[40] : 1'b0;
          q.base_hi <= csr_wdata_i[31:20];
        end
        if (wr_mask) q.mask_hi <= csr_wdata_i[31:20];
        if (wr_tba)  q.tba_hi  <= csr_wdata_i[34:10];
      end
    end

    assign cfg_o[w] = q;

    if (!LAST) begin : g_nodac
      AST_DAC_ONLY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_base |=> !q.dac);  // R2
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ctl_q <= '0;
    else if (csr_we_i && ctl_sel) ctl_q <= (ctl_q & ~CTL_WMASK) | (csr_wdata_i & CTL_WMASK);
  end

  assign hole_en_o = ctl_q[HOLE_BIT];

  always_comb begin
    win_cfg_t c;
    c = cfg_o[widx];
    csr_rdata_o = '0;
    if (ctl_sel) begin
      csr_rdata_o = ctl_q;
    end else if (win_sel) begin
      unique case (grp)
        GRP_BASE: csr_rdata_o = {23'd0, c.dac, 8'd0, c.base_hi, 18'd0, c.sg, c.en};
        GRP_MASK: csr_rdata_o = {32'd0, c.mask_hi, 20'd0};
        GRP_TBA:  csr_rdata_o = {29'd0, c.tba_hi, 10'd0};
        default:  csr_rdata_o = '0;
      endcase
    end
  end

  AST_CTL_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && ctl_sel) |=> (((ctl_q ^ $past(ctl_q)) & ~CTL_WMASK) == '0));  // R4
  AST_UNDEF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !ctl_sel && !win_sel) |=> $stable(ctl_q));  // R5
endmodule

// File: rtl/dmaw_win_match.sv
module dmaw_win_match
  import dmaw_pkg::*;
#(
  parameter bit IS_LAST = 1'b0
) (
  input  win_cfg_t            cfg_i,
  input  logic [BUS_AW-1:0]   addr_i,
  output logic                hit_o,
  output logic [SYS_AW-1:0]   sys_addr_o,
  output logic [SYS_AW-1:0]   pte_addr_o
);
  logic [BUS_AW-1:0] wsm, wsm_ext, base;
  logic [SYS_AW-1:0] tba, wsm_sh, idx_sh;

  assign wsm     = {cfg_i.mask_hi, 20'd0};
  assign wsm_ext = wsm | PAGE_MASK;
  assign base    = {cfg_i.base_hi, 20'd0};
  assign tba     = {cfg_i.tba_hi, 10'd0};

  // last window is blocked while its dual-address enable is set
  assign hit_o = cfg_i.en && ((addr_i & ~wsm_ext) == base) && (!IS_LAST || !cfg_i.dac);

  assign sys_addr_o = (tba & ~SYS_AW'(wsm_ext)) | SYS_AW'(addr_i & wsm_ext);

  assign wsm_sh     = SYS_AW'(wsm >> 10);
  assign idx_sh     = SYS_AW'((addr_i & (wsm | SG_IDX_MASK)) >> 10);
  assign pte_addr_o = (tba & ~wsm_sh) | idx_sh;
endmodule

// File: rtl/dmaw_select.sv
module dmaw_select
  import dmaw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BUS_AW-1:0]   addr_i,
  input  logic                hole_en_i,
  input  logic [NUM_WIN-1:0]  hit_vec_i,
  input  logic [NUM_WIN-1:0]  sg_vec_i,
  input  logic [SYS_AW-1:0]   sys_i [NUM_WIN],
  input  logic [SYS_AW-1:0]   pte_i [NUM_WIN],
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                sg_o,
  output logic [SYS_AW-1:0]   sys_addr_o,
  output logic [SYS_AW-1:0]   pte_addr_o
);
  logic in_hole;

  assign in_hole = hole_en_i && (addr_i >= HOLE_LO) && (addr_i <= HOLE_HI);

  always_comb begin
    hit_o      = 1'b0;
    idx_o      = '0;
    sg_o       = 1'b0;
    sys_addr_o = '0;
    pte_addr_o = '0;
    // descending walk so the lowest index is assigned last
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec_i[i] && !in_hole) begin
        hit_o      = 1'b1;
        idx_o      = IDX_W'(i);
        sg_o       = sg_vec_i[i];
        sys_addr_o = sg_vec_i[i] ? '0 : sys_i[i];
        pte_addr_o = sg_vec_i[i] ? pte_i[i] : '0;
      end
    end
  end

  AST_HOLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hole |-> !hit_o);  // R11
  AST_PRIO_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((hit_vec_i & ((NUM_WIN'(1) << idx_o) - NUM_WIN'(1))) == '0));  // R9
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (sys_addr_o == '0 && pte_addr_o == '0 && !sg_o));  // R12
endmodule

// File: rtl/dmaw_unit.sv
module dmaw_unit
  import dmaw_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 csr_we_i,
  input  logic [CSR_AW-1:0]    csr_addr_i,
  input  logic [CSR_DW-1:0]    csr_wdata_i,
  output logic [CSR_DW-1:0]    csr_rdata_o,
  input  logic [BUS_AW-1:0]    lk_addr_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic                 sg_o,
  output logic [SYS_AW-1:0]    sys_addr_o,
  output logic [SYS_AW-1:0]    pte_addr_o
);
  win_cfg_t           cfg [NUM_WIN];
  logic               hole_en;
  logic [NUM_WIN-1:0] hit_vec, sg_vec;
  logic [SYS_AW-1:0]  sys_w [NUM_WIN];
  logic [SYS_AW-1:0]  pte_w [NUM_WIN];

  dmaw_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_we_i    (csr_we_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .cfg_o       (cfg),
    .hole_en_o   (hole_en)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    dmaw_win_match #(.IS_LAST(w == NUM_WIN - 1)) u_match (
      .cfg_i      (cfg[w]),
      .addr_i     (lk_addr_i),
      .hit_o      (hit_vec[w]),
      .sys_addr_o (sys_w[w]),
      .pte_addr_o (pte_w[w])
    );
    assign sg_vec[w] = cfg[w].sg;
  end

  dmaw_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (lk_addr_i),
    .hole_en_i  (hole_en),
    .hit_vec_i  (hit_vec),
    .sg_vec_i   (sg_vec),
    .sys_i      (sys_w),
    .pte_i      (pte_w),
    .hit_o      (hit_o),
    .idx_o      (win_idx_o),
    .sg_o       (sg_o),
    .sys_addr_o (sys_addr_o),
    .pte_addr_o (pte_addr_o)
  );

  AST_HIT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> cfg[win_idx_o].en);  // R6
  AST_LAST_DAC_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (32'(win_idx_o) == NUM_WIN - 1)) |-> !cfg[NUM_WIN-1].dac);  // R10
  AST_SG_PTE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && sg_o) |-> (pte_addr_o[2:0] == 3'd0));  // R8
endmodule

// File: tb/tb_dmaw_unit.sv
module tb_dmaw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [31:0] lk = '0;
  logic        hit, sg;
  logic [1:0]  idx;
  logic [34:0] sys, pte;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dmaw_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .lk_addr_i(lk),
    .hit_o(hit), .win_idx_o(idx), .sg_o(sg), .sys_addr_o(sys), .pte_addr_o(pte)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic look(input logic [31:0] a);
    lk = a;
    #1;
  endtask

  task automatic chk_lookup(input string req, input logic [31:0] a, input logic eh,
                            input logic [1:0] ei, input logic es,
                            input logic [34:0] esys, input logic [34:0] epte);
    look(a);
    chk({req, " hit"}, 64'(hit), 64'(eh));
    if (eh) begin
      chk({req, " idx"}, 64'(idx), 64'(ei));
      chk({req, " sg"}, 64'(sg), 64'(es));
    end else begin
      chk({req, " sg"}, 64'(sg), 64'd0);
    end
    chk({req, " sys"}, 64'(sys), 64'(esys));
    chk({req, " pte"}, 64'(pte), 64'(epte));
  endtask

  task automatic clear_all();
    for (int w = 0; w < 4; w++) begin
      wr(10'(w * 64), 64'd0);
      wr(10'(256 + w * 64), 64'd0);
      wr(10'(512 + w * 64), 64'd0);
    end
    wr(10'h300, 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int w = 0; w < 4; w++) begin
      rd(10'(w * 64), d);       chk("R1 base reset", d, (w == 3) ? 64'h2 : 64'h0);
      rd(10'(256 + w * 64), d); chk("R1 mask reset", d, 64'h0);
      rd(10'(512 + w * 64), d); chk("R1 tba reset", d, 64'h0);
    end
    rd(10'h300, d); chk("R1 ctl reset", d, 64'h0);
    chk_lookup("R12 reset miss", 32'h0, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
  endtask

  task automatic t_masks();
    logic [63:0] d;
    for (int w = 0; w < 4; w++) begin
      wr(10'(w * 64), '1);
      rd(10'(w * 64), d);
      chk("R2 base keep", d, (w == 3) ? 64'h100_FFF0_0003 : 64'hFFF0_0003);
      wr(10'(256 + w * 64), '1);
      rd(10'(256 + w * 64), d); chk("R3 mask keep", d, 64'hFFF0_0000);
      wr(10'(512 + w * 64), '1);
      rd(10'(512 + w * 64), d); chk("R3 tba keep", d, 64'h7_FFFF_FC00);
    end
    wr(10'h0C0, 64'h0);
    rd(10'h0C0, d); chk("R2 last sg forced", d, 64'h2);
    wr(10'h300, '1);
    rd(10'h300, d); chk("R4 ctl writable bits", d, 64'h00001CFF0FC7FF);
    wr(10'h300, 64'h0);
    rd(10'h300, d); chk("R4 ctl clear", d, 64'h0);
    clear_all();
  endtask

  task automatic t_undef();
    logic [63:0] d;
    wr(10'h000, 64'h1234_5678_9ABC_DEF1);
    wr(10'h008, '1);
    wr(10'h340, '1);
    wr(10'h3C0, '1);
    rd(10'h008, d); chk("R5 undef read 008", d, 64'h0);
    rd(10'h340, d); chk("R5 undef read 340", d, 64'h0);
    rd(10'h000, d); chk("R5 base untouched", d, 64'h9AB0_0001);
    rd(10'h300, d); chk("R5 ctl untouched", d, 64'h0);
    rd(10'h100, d); chk("R5 mask untouched", d, 64'h0);
    clear_all();
  endtask

  task automatic t_direct();
    wr(10'h000, 64'h4000_0001);
    wr(10'h100, 64'h0FF0_0000);
    wr(10'h200, 64'h1_2000_0000);
    chk_lookup("R7 direct", 32'h4123_4567, 1'b1, 2'd0, 1'b0, 35'h1_2123_4567, 35'h0);
    chk_lookup("R6 direct top", 32'h4FFF_FFF8, 1'b1, 2'd0, 1'b0, 35'h1_2FFF_FFF8, 35'h0);
    chk_lookup("R6 outside", 32'h5000_0000, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
    chk_lookup("R12 below", 32'h3FFF_FFFF, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
    wr(10'h000, 64'h4000_0000);
    chk_lookup("R6 disabled", 32'h4123_4567, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
    clear_all();
  endtask

  task automatic t_sg();
    wr(10'h040, 64'h8000_0003);
    wr(10'h140, 64'h0010_0000);
    wr(10'h240, 64'h2_0000_0000);
    chk_lookup("R8 sg", 32'h8012_3456, 1'b1, 2'd1, 1'b1, 35'h0, 35'h2_0000_0488);
    chk_lookup("R8 sg low", 32'h8000_1FFF, 1'b1, 2'd1, 1'b1, 35'h0, 35'h2_0000_0000);
    chk_lookup("R6 sg outside", 32'h8020_0000, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
    clear_all();
  endtask

  task automatic t_prio();
    wr(10'h000, 64'h4000_0001);
    wr(10'h200, 64'h1_0000_0000);
    wr(10'h080, 64'h4000_0001);
    wr(10'h280, 64'h3_0000_0000);
    chk_lookup("R9 lowest wins", 32'h4000_1000, 1'b1, 2'd0, 1'b0, 35'h1_0000_1000, 35'h0);
    wr(10'h000, 64'h4000_0000);
    chk_lookup("R9 next window", 32'h4000_1000, 1'b1, 2'd2, 1'b0, 35'h3_0000_1000, 35'h0);
    clear_all();
  endtask

  task automatic t_hole();
    wr(10'h000, 64'h0000_0001);
    wr(10'h200, 64'h4_0000_0000);
    chk_lookup("R11 hole off", 32'h0009_0000, 1'b1, 2'd0, 1'b0, 35'h4_0009_0000, 35'h0);
    wr(10'h300, 64'h20);
    chk_lookup("R11 hole lo", 32'h0008_0000, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
    chk_lookup("R11 hole hi", 32'h000F_FFFF, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
    chk_lookup("R11 below hole", 32'h0007_FFFF, 1'b1, 2'd0, 1'b0, 35'h4_0007_FFFF, 35'h0);
    clear_all();
  endtask

  task automatic t_last();
    wr(10'h0C0, 64'hC000_0001);
    wr(10'h2C0, 64'h1_0000_0000);
    chk_lookup("R10 last sg", 32'hC000_5000, 1'b1, 2'd3, 1'b1, 35'h0, 35'h1_0000_0010);
    wr(10'h0C0, 64'h100_C000_0001);
    chk_lookup("R10 dac blocks", 32'hC000_5000, 1'b0, 2'd0, 1'b0, 35'h0, 35'h0);
    wr(10'h0C0, 64'hC000_0001);
    chk_lookup("R10 dac cleared", 32'hC000_5000, 1'b1, 2'd3, 1'b1, 35'h0, 35'h1_0000_0010);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_undef();
    t_direct();
    t_sg();
    t_prio();
    t_hole();
    t_last();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule